// File: doc/BRIEF.md
# Set/Clear Command Register Bank

This block holds five 32-bit control registers that software updates through a set/clear write scheme instead of plain stores. Every register is split into four byte lanes. In each written lane the top bit is a value bit and the seven bits below it are select bits. Every selected, implemented bit takes the value bit. All other bits keep their state. Software can therefore raise or drop single control bits without a read-modify-write cycle, and without racing other agents that touch different bits.

The bank has a simple memory-mapped port: write enable, byte address, per-lane byte enables and write data, plus a separate read address with registered read data. Each register's full stored value is also driven on its own output port to the logic it controls. Each register has a fixed mask of implemented bits. Positions outside the mask, including the four value-bit positions, are never stored.

Top module: `cs_reg_bank`

## Requirements
- R1: The four byte lanes of a write are applied independently. Lane b covers bits 8b+7..8b, and each enabled lane uses only its own value bit, with no effect on other lanes.
- R2: Within an enabled lane, each of bits 8b+6..8b that is 1 in the write data and implemented is loaded with the lane's value bit, bit 8b+7. For example, byte 0 data 8'h9A sets bits 4, 3 and 1, and 8'h1A clears the same bits.
- R3: Stored bits whose select bit is 0 keep their previous value.
- R4: Bits outside a register's implemented mask are never stored and always read as zero. This includes bits 7, 15, 23 and 31.
- R5: A lane whose byte enable (wr_be[b]) is 0 is not changed, whatever its data bits are.
- R6: The register map is: byte offset 0x40 is the interrupt-enable register with mask 32'h1F7F7F1F; 0x48 has mask 32'h000F0F7F; 0x50 has 32'h3F7F3F7F; 0x54 has 32'h203C7E07; 0x64 has 32'h0000001B. Each register drives its own output port: q_ien, q_cmd0, q_cmd2, q_cmd3 and q_cmd7.
- R7: Writing a register's mask value with all four byte enables set, and therefore all value bits 0, clears every implemented bit of that register.
- R8: rd_data shows the register at rd_addr one clock edge after rd_addr is presented. A read changes no state.
- R9: A synchronous active-low reset (rst_n = 0 at a clock edge) clears every register and rd_data.
- R10: Writes to any other address, including offsets that are not word-aligned, change nothing. Reads from such addresses return zero.
- R11: With wr_en at 0, no register changes, whatever the address, byte enable and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (9) | Byte address of the write |
| wr_be | input | 4 | Per-lane byte enables |
| wr_data | input | 32 | Value and select bits, four lanes |
| rd_addr | input | ADDR_W (9) | Byte address of the read |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| q_ien | output | 32 | Interrupt-enable register state (0x40) |
| q_cmd0 | output | 32 | Command register state at 0x48 |
| q_cmd2 | output | 32 | Command register state at 0x50 |
| q_cmd3 | output | 32 | Command register state at 0x54 |
| q_cmd7 | output | 32 | Command register state at 0x64 |

## Verification
The checker enforces the following on every cycle: unimplemented bits stay zero, a disabled lane holds its value, an idle or unmapped write holds every register, reset leaves all registers clear, and rd_data follows the addressed register with one cycle of latency. The exact set and clear result of a write can only be shown by the bench scenarios. These cover the 9A/1A example, mixed per-lane value bits, preserving unselected bits, the mask-clear pattern and writes to unaligned or unmapped offsets. Each scenario is compared against a reference model of the update rule.

// File: rtl/cs_bank_pkg.sv
// Package: shared constants for the set/clear command register bank.
// Holds the lane geometry, the register count, the byte offsets and the
// implemented-bit masks. Offsets are compared against a zero-extended bus
// address of at most OFFS_W bits.
package cs_bank_pkg;
    localparam int DATA_W    = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int SEL_W     = LANE_W - 1;
    localparam int NUM_REGS  = 5;
    localparam int OFFS_W    = 16;

    typedef logic [DATA_W-1:0] word_t;

    // register index order: interrupt enable, then the four command registers
    localparam int IDX_IEN  = 0;
    localparam int IDX_CMD0 = 1;
    localparam int IDX_CMD2 = 2;
    localparam int IDX_CMD3 = 3;
    localparam int IDX_CMD7 = 4;

    localparam logic [OFFS_W-1:0] REG_OFFS [NUM_REGS] =
        '{16'h0040, 16'h0048, 16'h0050, 16'h0054, 16'h0064};

    localparam word_t REG_MASK [NUM_REGS] =
        '{32'h1F7F7F1F, 32'h000F0F7F, 32'h3F7F3F7F, 32'h203C7E07, 32'h0000001B};
endpackage

// File: rtl/cs_addr_decode.sv
// Module: cs_addr_decode
// Turns a byte address into a one-hot register select. Only exact,
// word-aligned offsets from the package hit; anything else gives all zeros.
// Assumes ADDR_W <= OFFS_W.
module cs_addr_decode
    import cs_bank_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);
    logic [OFFS_W-1:0] addr_ext;

    // zero-extend the bus address to the offset width
    always_comb addr_ext = OFFS_W'(addr);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cmp
        // one comparator per mapped register
        always_comb hit[r] = (addr_ext == REG_OFFS[r]);
    end
endmodule

// File: rtl/cs_cmd_reg.sv
// Module: cs_cmd_reg
// One 32-bit set/clear register. When sel is high, each enabled byte lane
// loads its lane value bit into every selected bit that MASK implements.
// Bits outside MASK are tied to zero and have no flop.
module cs_cmd_reg
    import cs_bank_pkg::*;
#(
    parameter word_t MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic [NUM_LANES-1:0] be,
    input  word_t                wdata,
    output word_t                q
);
    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        logic lane_we;
        logic lane_val;

        // lane is written only when the register is selected and enabled
        always_comb lane_we  = sel && be[b];
        // value bit is the top bit of the lane
        always_comb lane_val = wdata[b*LANE_W + SEL_W];

        for (genvar i = 0; i < LANE_W; i++) begin : g_bit
            localparam int POS = b*LANE_W + i;
            if (i < SEL_W && MASK[POS]) begin : g_impl
                // implemented bit: load the lane value when selected
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q[POS] <= 1'b0;
                    else if (lane_we && wdata[POS])
                        q[POS] <= lane_val;
                end
            end else begin : g_none
                // unimplemented position or value-bit slot: constant zero
                always_comb q[POS] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cs_read_mux.sv
// Module: cs_read_mux
// AND-OR read selector. Assumes hit is one-hot or all zeros; all zeros
// (an unmapped address) gives a zero word.
module cs_read_mux
    import cs_bank_pkg::*;
(
    input  logic [NUM_REGS-1:0] hit,
    input  word_t               regs [NUM_REGS],
    output word_t               data
);
    // merge the selected register into the output word
    always_comb begin
        data = '0;
        for (int r = 0; r < NUM_REGS; r++)
            data |= regs[r] & {DATA_W{hit[r]}};
    end
endmodule

// File: rtl/cs_reg_bank.sv
// Module: cs_reg_bank (top)
// Bank of five set/clear command registers with a byte-addressed write
// port, a separate read address with one cycle of latency, and a direct
// output per register. Assumes at most one write per cycle. Reads change
// no state.
module cs_reg_bank
    import cs_bank_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [31:0]       q_ien,
    output logic [31:0]       q_cmd0,
    output logic [31:0]       q_cmd2,
    output logic [31:0]       q_cmd3,
    output logic [31:0]       q_cmd7
);
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;
    word_t               regs [NUM_REGS];
    word_t               rd_word;

    cs_addr_decode #(.ADDR_W(ADDR_W)) u_wr_dec (.addr(wr_addr), .hit(wr_hit));
    cs_addr_decode #(.ADDR_W(ADDR_W)) u_rd_dec (.addr(rd_addr), .hit(rd_hit));

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        cs_cmd_reg #(.MASK(REG_MASK[r])) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (wr_en && wr_hit[r]),
            .be    (wr_be),
            .wdata (wr_data),
            .q     (regs[r])
        );
    end

    cs_read_mux u_rmux (.hit(rd_hit), .regs(regs), .data(rd_word));

    // register the read word for one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= rd_word;
    end

    // drive each register onto its own output port
    always_comb begin
        q_ien  = regs[IDX_IEN];
        q_cmd0 = regs[IDX_CMD0];
        q_cmd2 = regs[IDX_CMD2];
        q_cmd3 = regs[IDX_CMD3];
        q_cmd7 = regs[IDX_CMD7];
    end
endmodule

// File: rtl/cs_reg_bank_chk.sv
// Module: cs_reg_bank_chk
// Property checker bound to cs_reg_bank. It watches only ports and builds
// its own address match and read expectation from the package constants.
module cs_reg_bank_chk
    import cs_bank_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [3:0]        wr_be,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic [31:0]       q_ien,
    input logic [31:0]       q_cmd0,
    input logic [31:0]       q_cmd2,
    input logic [31:0]       q_cmd3,
    input logic [31:0]       q_cmd7
);
    logic [159:0] all_q;
    logic         wr_mapped;
    logic [31:0]  rd_expect;

    // concatenation of all register outputs
    always_comb all_q = {q_cmd7, q_cmd3, q_cmd2, q_cmd0, q_ien};

    // independent write address match
    always_comb begin
        wr_mapped = 1'b0;
        for (int r = 0; r < NUM_REGS; r++)
            if (OFFS_W'(wr_addr) == REG_OFFS[r]) wr_mapped = 1'b1;
    end

    // value the read port should present one cycle later
    always_comb begin
        case (OFFS_W'(rd_addr))
            REG_OFFS[IDX_IEN]:  rd_expect = q_ien;
            REG_OFFS[IDX_CMD0]: rd_expect = q_cmd0;
            REG_OFFS[IDX_CMD2]: rd_expect = q_cmd2;
            REG_OFFS[IDX_CMD3]: rd_expect = q_cmd3;
            REG_OFFS[IDX_CMD7]: rd_expect = q_cmd7;
            default:            rd_expect = '0;
        endcase
    end

    p_unimpl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_ien & ~REG_MASK[IDX_IEN]) == 0) && ((q_cmd0 & ~REG_MASK[IDX_CMD0]) == 0) &&
        ((q_cmd2 & ~REG_MASK[IDX_CMD2]) == 0) && ((q_cmd3 & ~REG_MASK[IDX_CMD3]) == 0) &&
        ((q_cmd7 & ~REG_MASK[IDX_CMD7]) == 0));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (all_q == '0 && rd_data == '0));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(all_q));

    p_unmapped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_mapped) |=> $stable(all_q));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rd_data == $past(rd_expect)));

    for (genvar b = 0; b < NUM_LANES; b++) begin : g_lane
        p_lane_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_be[b]) |=> $stable({q_ien[b*8 +: 8], q_cmd0[b*8 +: 8],
                q_cmd2[b*8 +: 8], q_cmd3[b*8 +: 8], q_cmd7[b*8 +: 8]}));
    end
endmodule

bind cs_reg_bank cs_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .rd_addr(rd_addr), .rd_data(rd_data), .q_ien(q_ien), .q_cmd0(q_cmd0),
    .q_cmd2(q_cmd2), .q_cmd3(q_cmd3), .q_cmd7(q_cmd7)
);

// File: tb/sim_cs_reg_bank.sv
// Scoreboard bench for cs_reg_bank. Driver tasks update a reference model
// and queue the expected read words; a monitor pops them when due.
module sim_cs_reg_bank;
    localparam int AW = 9;

    typedef struct {
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [3:0]    wr_be = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data, q_ien, q_cmd0, q_cmd2, q_cmd3, q_cmd7;

    int          cyc = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 0;
    item_t       sb [$];
    logic [31:0] mdl [5];

    // offsets and masks as listed in R6
    localparam logic [AW-1:0] OFF [5] = '{9'h040, 9'h048, 9'h050, 9'h054, 9'h064};
    localparam logic [31:0]   MSK [5] =
        '{32'h1F7F7F1F, 32'h000F0F7F, 32'h3F7F3F7F, 32'h203C7E07, 32'h0000001B};

    cs_reg_bank #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .q_ien(q_ien),
        .q_cmd0(q_cmd0), .q_cmd2(q_cmd2), .q_cmd3(q_cmd3), .q_cmd7(q_cmd7)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int idx_of(input logic [AW-1:0] a);
        for (int r = 0; r < 5; r++) if (OFF[r] == a) return r;
        return -1;
    endfunction

    // set/clear rule from R1..R5
    function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] m,
                                          input logic [3:0] be, input logic [31:0] d);
        logic [31:0] res = old;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 7; i++)
                if (be[b] && d[b*8+i] && m[b*8+i]) res[b*8+i] = d[b*8+7];
        return res;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        int r;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        r = idx_of(a);
        if (r >= 0) mdl[r] = apply(mdl[r], MSK[r], be, d);
    endtask

    // drive address and data with the strobe low (R11)
    task automatic idle_drive(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = a; wr_be = be; wr_data = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        item_t it;
        int r;
        @(negedge clk);
        wr_en = 1'b0; rd_addr = a;
        r = idx_of(a);
        it.exp = (r >= 0) ? mdl[r] : 32'h0;
        it.due = cyc + 1;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_ports(input string tag);
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " q_ien"},  q_ien,  mdl[0]);
        check({tag, " q_cmd0"}, q_cmd0, mdl[1]);
        check({tag, " q_cmd2"}, q_cmd2, mdl[2]);
        check({tag, " q_cmd3"}, q_cmd3, mdl[3]);
        check({tag, " q_cmd7"}, q_cmd7, mdl[4]);
    endtask

    task automatic rd_all(input string tag);
        for (int r = 0; r < 5; r++) rd(OFF[r], tag);
    endtask

    // monitor: compare queued expectations when the read data is due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, rd_data, it.exp);
        end
    end

    initial begin
        for (int r = 0; r < 5; r++) mdl[r] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk_ports("R9 reset state");
        rd_all("R9 reset read");

        // R2: example pattern on byte 0 of the 0x48 register
        wr(9'h048, 4'b0001, 32'h0000009A);
        chk_ports("R2 set 9A");
        rd(9'h048, "R2 set 9A read");
        wr(9'h048, 4'b0001, 32'h0000001A);
        rd(9'h048, "R2 clear 1A read");

        // R1: each lane with its own value bit
        wr(9'h050, 4'b1111, 32'hFF00FF00);
        rd(9'h050, "R1 lanes 3,1 set");
        wr(9'h050, 4'b1111, 32'h0381FF05);
        rd(9'h050, "R1 mixed lanes");

        // R3: unselected bits preserved
        wr(9'h040, 4'b1111, 32'h8A8A8A8A);
        wr(9'h040, 4'b1111, 32'h01010101);
        rd(9'h040, "R3 unselected kept");

        // R4: all ones keep only implemented bits
        wr(9'h064, 4'b1111, 32'hFFFFFFFF);
        wr(9'h054, 4'b1111, 32'hFFFFFFFF);
        chk_ports("R4 mask only");
        rd(9'h064, "R4 read 0x64");
        rd(9'h054, "R4 read 0x54");

        // R5: disabled lanes untouched
        wr(9'h054, 4'b0000, 32'h007F007F);
        rd(9'h054, "R5 no lanes");
        wr(9'h054, 4'b0100, 32'h7F7F7F7F);
        rd(9'h054, "R5 lane2 only");

        // R6: every mapped register set fully, read back
        for (int r = 0; r < 5; r++) wr(OFF[r], 4'b1111, 32'hFFFFFFFF);
        rd_all("R6 map full");

        // R10: unmapped and unaligned writes, reads return zero
        wr(9'h044, 4'b1111, 32'h7F7F7F7F);
        wr(9'h049, 4'b1111, 32'h7F7F7F7F);
        wr(9'h1FC, 4'b1111, 32'h7F7F7F7F);
        chk_ports("R10 unmapped write");
        rd(9'h044, "R10 read 0x44");
        rd(9'h04A, "R10 read 0x4A");

        // R11: strobe low, nothing changes
        idle_drive(9'h040, 4'b1111, 32'h7F7F7F7F);
        idle_drive(9'h050, 4'b1111, 32'h7F7F7F7F);
        chk_ports("R11 idle");

        // R8: repeated reads, no side effect
        rd(9'h050, "R8 read a");
        rd(9'h050, "R8 read b");
        chk_ports("R8 after reads");

        // R7: writing the mask clears all implemented bits
        for (int r = 0; r < 5; r++) wr(OFF[r], 4'b1111, MSK[r]);
        chk_ports("R7 mask clear");
        rd_all("R7 mask clear read");

        // R9: reset in the middle of operation
        wr(9'h048, 4'b1111, 32'h808F8FFF);
        @(negedge clk); wr_en = 1'b0; rst_n = 1'b0;
        for (int r = 0; r < 5; r++) mdl[r] = '0;
        @(negedge clk); rst_n = 1'b1;
        chk_ports("R9 mid reset");
        rd_all("R9 mid reset read");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule